// File: doc/BRIEF.md
# Path Overhead Byte Inserter

This block sits on the transmit side of a synchronous optical framer, after the pointer and payload mapping logic. It takes a byte stream in which an upstream position counter flags every byte that belongs to the path payload envelope. That counter also flags the nine path overhead slots and gives the row index of each slot. The block rewrites those nine slots with freshly generated path overhead and passes every other byte through untouched, with one clock of latency.

The parity slot carries an even BIP-8 computed over the envelope of the previous frame, with an optional forced inversion for test. The status slot reports two things back to the far end. Its upper nibble carries the count of path parity errors seen by the local receiver, either as a saturating count or as a single flag. Its next three bits carry a remote defect code built from nine alarm inputs, each with its own enable, in either the single-bit legacy form or the three-bit enhanced form. The trace, label, user, multiframe and growth slots take static values from configuration inputs.

Top module: `poh_inserter`

## Requirements
- R1: While rst_n is low at a clock edge, out_byte, out_spe and out_poh are 0 after that edge. Every output is registered, one cycle after its input.
- R2: Any byte not at an active overhead slot (in_spe and in_poh both high) appears unchanged on out_byte one cycle later. out_spe and out_poh repeat in_spe and in_poh one cycle later.
- R3: Row index codes are 0 trace, 1 parity, 2 label, 3 status, 4 user, 5 multiframe, 6 growth-A, 7 growth-B, 8 growth-C. Slots 0, 2 and 4 to 8 output cfg_trace, cfg_label, cfg_user, cfg_mframe, cfg_grow_a, cfg_grow_b and cfg_grow_c. Row codes 9 to 15 pass the input through.
- R4: The parity slot carries the XOR of every output envelope byte from one trace slot (inclusive) up to the next trace slot (exclusive). It appears in the frame that the later trace slot opens, and is 0 until the first such window has closed.
- R5: With cfg_par_inv high, all eight bits of the parity slot are inverted.
- R6: In the status byte, bit 1 is out_byte[7] and bit 8 is out_byte[0]. Bit 8 is always 0.
- R7: rx_err_stb adds rx_err_cnt to a pending count, saturating at 8. The pending count is reported and cleared at each status slot. A strobe in the status-slot cycle counts toward the next report. With cfg_rei_block low, bits 1 to 4 hold the pending count.
- R8: With cfg_rei_block high, bits 1 to 4 are 0001 when the pending count is nonzero and 0000 otherwise.
- R9: alarm_in and cfg_rdi_en bit order is 0 LOS, 1 LOF, 2 line AIS, 3 path AIS, 4 path LOP, 5 path TIM, 6 path UNEQ, 7 path LCD, 8 path PLM. Alarms are sampled in the status-slot cycle. An alarm whose enable bit is clear has no effect.
- R10: With cfg_rdi_enh low, bits 5 to 7 are 100 when any enabled alarm is active and 000 otherwise.
- R11: With cfg_rdi_enh high, bits 5 to 7 are chosen in priority order. A server alarm (bits 0 to 4) gives 101. Otherwise a connectivity alarm (5, 6) gives 110. Otherwise a payload alarm (7, 8) gives 010. With no enabled alarm active the code is 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte | input | 8 | Incoming stream byte |
| in_spe | input | 1 | Byte belongs to the payload envelope |
| in_poh | input | 1 | Byte is a path overhead slot |
| in_poh_row | input | 4 | Overhead row index, valid with in_poh |
| alarm_in | input | 9 | Receive-side alarm levels |
| rx_err_stb | input | 1 | Receive parity error count strobe |
| rx_err_cnt | input | CNT_W | Errors reported with the strobe |
| cfg_trace | input | 8 | Trace slot value |
| cfg_label | input | 8 | Signal label slot value |
| cfg_user | input | 8 | User channel slot value |
| cfg_mframe | input | 8 | Multiframe slot value |
| cfg_grow_a | input | 8 | Growth slot A value |
| cfg_grow_b | input | 8 | Growth slot B value |
| cfg_grow_c | input | 8 | Growth slot C value |
| cfg_par_inv | input | 1 | Invert the inserted parity |
| cfg_rei_block | input | 1 | Error report as single flag |
| cfg_rdi_enh | input | 1 | Enhanced defect code |
| cfg_rdi_en | input | 9 | Per-alarm defect enables |
| out_byte | output | 8 | Outgoing stream byte |
| out_spe | output | 1 | Delayed in_spe |
| out_poh | output | 1 | Delayed in_poh |

## Verification
The bench compares every output byte against its own model across several frames. The parity window is the first target. A design that closes the window at the wrong slot, or that leaves out the overwritten bytes, puts a wrong B3 in every frame after the first. The error count is exercised with a sum of two reports that overflows 8, with a strobe landing in the status-slot cycle, and in flag mode. A design that wraps instead of saturating, or that drops or double-counts the coincident strobe, reports a wrong nibble. The defect code is exercised with alarms that are active but disabled, and with server and connectivity alarms at once. A design that ignores the enables or ranks the classes wrongly emits the wrong code.

// File: rtl/poh_pkg.sv
// Shared constants and types for the path overhead inserter.
// Assumes: byte-wide stream, nine overhead rows, nine alarm sources.
package poh_pkg;
    localparam int BYTE_W  = 8;
    localparam int ROW_W   = 4;
    localparam int N_ALARM = 9;
    localparam int REI_W   = 4;
    localparam int RDI_W   = 3;

    // Overhead row codes; order follows the column position in the frame.
    typedef enum logic [ROW_W-1:0] {
        ROW_TRACE  = 4'd0,
        ROW_PAR    = 4'd1,
        ROW_LABEL  = 4'd2,
        ROW_STATUS = 4'd3,
        ROW_USER   = 4'd4,
        ROW_MFRAME = 4'd5,
        ROW_GROW_A = 4'd6,
        ROW_GROW_B = 4'd7,
        ROW_GROW_C = 4'd8
    } poh_row_e;

    // Alarm classes by bit position in alarm_in.
    localparam logic [N_ALARM-1:0] SERVER_MASK  = 9'b0_0001_1111;
    localparam logic [N_ALARM-1:0] CONNECT_MASK = 9'b0_0110_0000;
    localparam logic [N_ALARM-1:0] PAYLOAD_MASK = 9'b1_1000_0000;

    // Defect codes for status bits 5..7.
    localparam logic [RDI_W-1:0] RDI_NONE_OLD = 3'b000;
    localparam logic [RDI_W-1:0] RDI_ANY_OLD  = 3'b100;
    localparam logic [RDI_W-1:0] RDI_SERVER   = 3'b101;
    localparam logic [RDI_W-1:0] RDI_CONNECT  = 3'b110;
    localparam logic [RDI_W-1:0] RDI_PAYLOAD  = 3'b010;
    localparam logic [RDI_W-1:0] RDI_NONE_ENH = 3'b001;
endpackage

// File: rtl/poh_bip_acc.sv
// Frame-window even parity accumulator.
// Folds every valid byte into a running XOR. At a restart the finished
// window moves into the hold register and a new window opens with the
// restart byte. Assumes restart only occurs on valid bytes.
module poh_bip_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic         restart,
    input  logic [W-1:0] data,
    output logic [W-1:0] bip_prev
);
    logic [W-1:0] acc;
    logic [W-1:0] hold;

    // Running XOR and closed-window hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            hold <= '0;
        end else if (restart) begin
            hold <= acc;
            acc  <= data;
        end else if (valid) begin
            acc  <= acc ^ data;
        end
    end

    assign bip_prev = hold;
endmodule

// File: rtl/poh_rei_gen.sv
// Remote error indication generator.
// Gathers receive parity error counts between status slots with
// saturation, and forms the 4-bit report as a count or a flag.
// Assumes: consume is high for exactly the status-slot cycle.
module poh_rei_gen
    import poh_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int REI_SAT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_stb,
    input  logic [CNT_W-1:0] err_cnt,
    input  logic             consume,
    input  logic             block_mode,
    output logic [REI_W-1:0] rei_field
);
    localparam int PEND_W = $clog2(REI_SAT + 1);
    localparam int SUM_W  = (PEND_W > CNT_W ? PEND_W : CNT_W) + 1;
    localparam logic [SUM_W-1:0] SAT_V = SUM_W'(REI_SAT);

    logic [PEND_W-1:0] pend;
    logic [SUM_W-1:0]  sum_raw;
    logic [SUM_W-1:0]  fresh_raw;
    logic [PEND_W-1:0] sum_sat;
    logic [PEND_W-1:0] fresh_sat;

    // Saturating sums for the accumulate and restart paths.
    always_comb begin
        sum_raw   = SUM_W'(pend) + SUM_W'(err_cnt);
        fresh_raw = SUM_W'(err_cnt);
        sum_sat   = (sum_raw > SAT_V)   ? PEND_W'(REI_SAT) : PEND_W'(sum_raw);
        fresh_sat = (fresh_raw > SAT_V) ? PEND_W'(REI_SAT) : PEND_W'(fresh_raw);
    end

    // Pending count: cleared at report, coincident strobe starts next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (consume) begin
            pend <= err_stb ? fresh_sat : '0;
        end else if (err_stb) begin
            pend <= sum_sat;
        end
    end

    // Report format selection.
    always_comb begin
        if (block_mode) begin
            rei_field = (pend != '0) ? REI_W'(1) : '0;
        end else begin
            rei_field = REI_W'(pend);
        end
    end
endmodule

// File: rtl/poh_rdi_gen.sv
// Remote defect indication encoder.
// Masks alarms with their enables and produces the 3-bit code for
// status bits 5..7 in legacy or enhanced form. Purely combinational.
module poh_rdi_gen
    import poh_pkg::*;
(
    input  logic [N_ALARM-1:0] alarm,
    input  logic [N_ALARM-1:0] enable,
    input  logic               enhanced,
    output logic [RDI_W-1:0]   rdi_code
);
    logic [N_ALARM-1:0] active;
    logic               hit_server;
    logic               hit_connect;
    logic               hit_payload;

    // Enabled alarms, grouped by class.
    always_comb begin
        active      = alarm & enable;
        hit_server  = |(active & SERVER_MASK);
        hit_connect = |(active & CONNECT_MASK);
        hit_payload = |(active & PAYLOAD_MASK);
    end

    // Code selection with server > connectivity > payload priority.
    always_comb begin
        if (!enhanced) begin
            rdi_code = (|active) ? RDI_ANY_OLD : RDI_NONE_OLD;
        end else if (hit_server) begin
            rdi_code = RDI_SERVER;
        end else if (hit_connect) begin
            rdi_code = RDI_CONNECT;
        end else if (hit_payload) begin
            rdi_code = RDI_PAYLOAD;
        end else begin
            rdi_code = RDI_NONE_ENH;
        end
    end
endmodule

// File: rtl/poh_inserter.sv
// Path overhead byte inserter (top).
// Replaces the nine path overhead slots of an envelope byte stream with
// generated values and registers the stream by one cycle.
// Assumes: an upstream counter drives in_spe, in_poh and in_poh_row; one
// trace slot opens each frame; configuration is quasi-static.
module poh_inserter
    import poh_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int REI_SAT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  in_byte,
    input  logic               in_spe,
    input  logic               in_poh,
    input  logic [ROW_W-1:0]   in_poh_row,
    input  logic [N_ALARM-1:0] alarm_in,
    input  logic               rx_err_stb,
    input  logic [CNT_W-1:0]   rx_err_cnt,
    input  logic [BYTE_W-1:0]  cfg_trace,
    input  logic [BYTE_W-1:0]  cfg_label,
    input  logic [BYTE_W-1:0]  cfg_user,
    input  logic [BYTE_W-1:0]  cfg_mframe,
    input  logic [BYTE_W-1:0]  cfg_grow_a,
    input  logic [BYTE_W-1:0]  cfg_grow_b,
    input  logic [BYTE_W-1:0]  cfg_grow_c,
    input  logic               cfg_par_inv,
    input  logic               cfg_rei_block,
    input  logic               cfg_rdi_enh,
    input  logic [N_ALARM-1:0] cfg_rdi_en,
    output logic [BYTE_W-1:0]  out_byte,
    output logic               out_spe,
    output logic               out_poh
);
    logic              slot_act;
    logic              at_trace;
    logic              at_status;
    logic [BYTE_W-1:0] bip_prev;
    logic [REI_W-1:0]  rei_field;
    logic [RDI_W-1:0]  rdi_code;
    logic [BYTE_W-1:0] status_byte;
    logic [BYTE_W-1:0] nxt_byte;

    // Slot decode.
    always_comb begin
        slot_act  = in_spe && in_poh;
        at_trace  = slot_act && (in_poh_row == ROW_TRACE);
        at_status = slot_act && (in_poh_row == ROW_STATUS);
    end

    poh_bip_acc #(
        .W(BYTE_W)
    ) u_bip (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (in_spe),
        .restart  (at_trace),
        .data     (nxt_byte),
        .bip_prev (bip_prev)
    );

    poh_rei_gen #(
        .CNT_W   (CNT_W),
        .REI_SAT (REI_SAT)
    ) u_rei (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_stb    (rx_err_stb),
        .err_cnt    (rx_err_cnt),
        .consume    (at_status),
        .block_mode (cfg_rei_block),
        .rei_field  (rei_field)
    );

    poh_rdi_gen u_rdi (
        .alarm    (alarm_in),
        .enable   (cfg_rdi_en),
        .enhanced (cfg_rdi_enh),
        .rdi_code (rdi_code)
    );

    // Status byte assembly: report nibble, defect code, spare bit 0.
    assign status_byte = {rei_field, rdi_code, 1'b0};

    // Byte selection per overhead row.
    always_comb begin
        nxt_byte = in_byte;
        if (slot_act) begin
            case (in_poh_row)
                ROW_TRACE:  nxt_byte = cfg_trace;
                ROW_PAR:    nxt_byte = bip_prev ^ {BYTE_W{cfg_par_inv}};
                ROW_LABEL:  nxt_byte = cfg_label;
                ROW_STATUS: nxt_byte = status_byte;
                ROW_USER:   nxt_byte = cfg_user;
                ROW_MFRAME: nxt_byte = cfg_mframe;
                ROW_GROW_A: nxt_byte = cfg_grow_a;
                ROW_GROW_B: nxt_byte = cfg_grow_b;
                ROW_GROW_C: nxt_byte = cfg_grow_c;
                default:    nxt_byte = in_byte;
            endcase
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= '0;
            out_spe  <= 1'b0;
            out_poh  <= 1'b0;
        end else begin
            out_byte <= nxt_byte;
            out_spe  <= in_spe;
            out_poh  <= in_poh;
        end
    end
endmodule

// File: rtl/poh_inserter_chk.sv
// Property checker for poh_inserter, attached by bind.
// Assumes the row codes and status layout of poh_pkg.
module poh_inserter_chk
    import poh_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [BYTE_W-1:0]  in_byte,
    input logic               in_spe,
    input logic               in_poh,
    input logic [ROW_W-1:0]   in_poh_row,
    input logic [N_ALARM-1:0] alarm_in,
    input logic [BYTE_W-1:0]  cfg_label,
    input logic               cfg_par_inv,
    input logic               cfg_rei_block,
    input logic               cfg_rdi_enh,
    input logic [N_ALARM-1:0] cfg_rdi_en,
    input logic [BYTE_W-1:0]  bip_prev,
    input logic [BYTE_W-1:0]  out_byte,
    input logic               out_spe,
    input logic               out_poh
);
    logic st_slot;
    assign st_slot = in_spe && in_poh && (in_poh_row == ROW_STATUS);

    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_spe && in_poh) |=> out_byte == $past(in_byte));

    assert_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_spe == $past(in_spe)) && (out_poh == $past(in_poh)));

    assert_label_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_spe && in_poh && in_poh_row == ROW_LABEL) |=> out_byte == $past(cfg_label));

    // R4 and R5: parity slot carries the closed window, optionally inverted.
    assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_spe && in_poh && in_poh_row == ROW_PAR)
        |=> out_byte == ($past(bip_prev) ^ {BYTE_W{$past(cfg_par_inv)}}));

    assert_spare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_slot |=> out_byte[0] == 1'b0);

    assert_rei_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_slot && !cfg_rei_block) |=> out_byte[7:4] <= 4'd8);

    assert_rei_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_slot && cfg_rei_block) |=> out_byte[7:5] == 3'b000);

    assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_slot && !cfg_rdi_enh && ((alarm_in & cfg_rdi_en) == '0)) |=> out_byte[3] == 1'b0);

    assert_legacy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_slot && !cfg_rdi_enh) |=> out_byte[2:1] == 2'b00);

    assert_enh_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_slot && cfg_rdi_enh) |=> out_byte[3:1] != 3'b000);
endmodule

bind poh_inserter poh_inserter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_byte       (in_byte),
    .in_spe        (in_spe),
    .in_poh        (in_poh),
    .in_poh_row    (in_poh_row),
    .alarm_in      (alarm_in),
    .cfg_label     (cfg_label),
    .cfg_par_inv   (cfg_par_inv),
    .cfg_rei_block (cfg_rei_block),
    .cfg_rdi_enh   (cfg_rdi_enh),
    .cfg_rdi_en    (cfg_rdi_en),
    .bip_prev      (bip_prev),
    .out_byte      (out_byte),
    .out_spe       (out_spe),
    .out_poh       (out_poh)
);

// File: tb/tb_poh_inserter.sv
`timescale 1ns/1ps
module tb_poh_inserter;
    localparam int ROWS = 9;
    localparam int COLS = 12;
    localparam int TOH  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_spe = 1'b0;
    logic       in_poh = 1'b0;
    logic [3:0] in_poh_row = '0;
    logic [8:0] alarm_in = '0;
    logic       rx_err_stb = 1'b0;
    logic [3:0] rx_err_cnt = '0;
    logic [7:0] cfg_trace = 8'h5A, cfg_label = 8'h13, cfg_user = 8'hC1;
    logic [7:0] cfg_mframe = 8'h7E, cfg_grow_a = 8'h21, cfg_grow_b = 8'h42, cfg_grow_c = 8'h84;
    logic       cfg_par_inv = 1'b0, cfg_rei_block = 1'b0, cfg_rdi_enh = 1'b0;
    logic [8:0] cfg_rdi_en = '1;
    logic [7:0] out_byte;
    logic       out_spe, out_poh;

    int vectors = 0;
    int fails = 0;

    // Bench model state
    logic [7:0] m_acc = '0, m_hold = '0;
    int         m_pend = 0;
    logic       have_prev = 1'b0;
    logic [9:0] exp_prev;
    string      tag_prev;

    always #2.5 clk = ~clk;

    poh_inserter dut (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_spe(in_spe), .in_poh(in_poh),
        .in_poh_row(in_poh_row), .alarm_in(alarm_in), .rx_err_stb(rx_err_stb),
        .rx_err_cnt(rx_err_cnt), .cfg_trace(cfg_trace), .cfg_label(cfg_label),
        .cfg_user(cfg_user), .cfg_mframe(cfg_mframe), .cfg_grow_a(cfg_grow_a),
        .cfg_grow_b(cfg_grow_b), .cfg_grow_c(cfg_grow_c), .cfg_par_inv(cfg_par_inv),
        .cfg_rei_block(cfg_rei_block), .cfg_rdi_enh(cfg_rdi_enh), .cfg_rdi_en(cfg_rdi_en),
        .out_byte(out_byte), .out_spe(out_spe), .out_poh(out_poh)
    );

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got spe/poh/byte %03h expected %03h", tag, got, exp);
        end
    endtask

    // Status byte from the requirements (R6..R11).
    function automatic logic [7:0] exp_status(input int pend);
        logic [3:0] rei;
        logic [2:0] rdi;
        logic [8:0] act;
        rei = cfg_rei_block ? ((pend != 0) ? 4'd1 : 4'd0) : 4'(pend);
        act = alarm_in & cfg_rdi_en;
        if (!cfg_rdi_enh)            rdi = (act != 0) ? 3'b100 : 3'b000;
        else if (act[4:0] != 0)      rdi = 3'b101;
        else if (act[6:5] != 0)      rdi = 3'b110;
        else if (act[8:7] != 0)      rdi = 3'b010;
        else                         rdi = 3'b001;
        return {rei, rdi, 1'b0};
    endfunction

    // One byte per cycle; checks the byte driven one cycle earlier.
    task automatic drive_byte(input logic [7:0] b, input logic spe, input logic poh,
                              input logic [3:0] row, input logic stb, input logic [3:0] cnt,
                              input string gtag);
        logic [7:0] e;
        string t;
        @(negedge clk);
        if (have_prev) check(tag_prev, {out_spe, out_poh, out_byte}, exp_prev);
        in_byte = b; in_spe = spe; in_poh = poh; in_poh_row = row;
        rx_err_stb = stb; rx_err_cnt = cnt;
        e = b; t = "R2";
        if (spe && poh) begin
            case (row)
                4'd0: begin e = cfg_trace;  t = "R3"; end
                4'd1: begin e = m_hold ^ {8{cfg_par_inv}}; t = cfg_par_inv ? "R5" : "R4"; end
                4'd2: begin e = cfg_label;  t = "R3"; end
                4'd3: begin e = exp_status(m_pend); t = gtag; end
                4'd4: begin e = cfg_user;   t = "R3"; end
                4'd5: begin e = cfg_mframe; t = "R3"; end
                4'd6: begin e = cfg_grow_a; t = "R3"; end
                4'd7: begin e = cfg_grow_b; t = "R3"; end
                4'd8: begin e = cfg_grow_c; t = "R3"; end
                default: begin e = b; t = "R3"; end
            endcase
        end
        if (spe && poh && row == 4'd0) begin
            m_hold = m_acc; m_acc = e;
        end else if (spe) begin
            m_acc = m_acc ^ e;
        end
        if (spe && poh && row == 4'd3) m_pend = stb ? ((cnt > 8) ? 8 : int'(cnt)) : 0;
        else if (stb) m_pend = (m_pend + int'(cnt) > 8) ? 8 : m_pend + int'(cnt);
        exp_prev = {spe, poh, e};
        tag_prev = t;
        have_prev = 1'b1;
    endtask

    // One frame: three transport columns, envelope with overhead in column TOH.
    task automatic run_frame(input int seed, input int e1, input logic [3:0] c1,
                             input int e2, input logic [3:0] c2, input string gtag);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int k;
                logic [7:0] b;
                k = r * COLS + c;
                b = 8'((k * 37 + seed * 91 + 5) ^ (k >> 2));
                drive_byte(b, c >= TOH, c == TOH, 4'(r),
                           (k == e1) || (k == e2), (k == e1) ? c1 : ((k == e2) ? c2 : 4'd0), gtag);
            end
        end
    endtask

    task automatic flush();
        drive_byte(8'hEE, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R2");
    endtask

    localparam int ST_IDX = 3 * COLS + TOH; // status slot position in a frame

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {out_spe, out_poh, out_byte}, 10'h000);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        run_frame(1, -1, 0, -1, 0, "R6");
        run_frame(2, -1, 0, -1, 0, "R6");
        drive_byte(8'h99, 1'b1, 1'b1, 4'd12, 1'b0, 4'd0, "R3"); // unused row code
        drive_byte(8'h66, 1'b0, 1'b1, 4'd1, 1'b0, 4'd0, "R2");  // slot outside envelope
        run_frame(3, -1, 0, -1, 0, "R6");
        flush();
    endtask

    task automatic t_par_inv();
        cfg_par_inv = 1'b1;
        run_frame(4, -1, 0, -1, 0, "R6");
        flush();
        cfg_par_inv = 1'b0;
        run_frame(5, -1, 0, -1, 0, "R6");
        flush();
    endtask

    task automatic t_rei_count();
        cfg_rei_block = 1'b0;
        run_frame(6, 5, 4'd3, -1, 0, "R7");          // 3
        run_frame(7, 2, 4'd5, 20, 4'd6, "R7");       // 5+6 saturates at 8
        run_frame(8, ST_IDX, 4'd2, -1, 0, "R7");     // coincident: reported 0
        run_frame(9, -1, 0, -1, 0, "R7");            // carried 2
        run_frame(10, 1, 4'd15, -1, 0, "R7");        // single over-range report
        flush();
    endtask

    task automatic t_rei_block();
        cfg_rei_block = 1'b1;
        run_frame(11, 4, 4'd4, -1, 0, "R8");
        run_frame(12, -1, 0, -1, 0, "R8");
        flush();
        cfg_rei_block = 1'b0;
    endtask

    task automatic t_rdi_legacy();
        cfg_rdi_enh = 1'b0;
        cfg_rdi_en = '1; alarm_in = 9'b0_0000_0001;
        run_frame(13, -1, 0, -1, 0, "R10");
        cfg_rdi_en = 9'b1_1111_1110;                  // LOS disabled
        run_frame(14, -1, 0, -1, 0, "R9");
        alarm_in = '0; cfg_rdi_en = '1;
        run_frame(15, -1, 0, -1, 0, "R10");
        flush();
    endtask

    task automatic t_rdi_enh();
        cfg_rdi_enh = 1'b1; cfg_rdi_en = '1;
        alarm_in = '0;                 run_frame(16, -1, 0, -1, 0, "R11");
        alarm_in = 9'b1_0000_0000;     run_frame(17, -1, 0, -1, 0, "R11");
        alarm_in = 9'b0_0010_0000;     run_frame(18, -1, 0, -1, 0, "R11");
        alarm_in = 9'b0_0010_1000;     run_frame(19, -1, 0, -1, 0, "R11");
        alarm_in = 9'b0_1000_0000; cfg_rdi_en = 9'b1_0111_1111;
        run_frame(20, -1, 0, -1, 0, "R9");
        flush();
        alarm_in = '0; cfg_rdi_en = '1; cfg_rdi_enh = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_par_inv();
        t_rei_count();
        t_rei_block();
        t_rdi_legacy();
        t_rdi_enh();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule